// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Emulation Engine

This block rebuilds the three classic real-time-clock interrupt sources (once-per-second update, time-of-day alarm and programmable periodic) on top of a free-running reference tick. It polls the time-of-day value that a separate counter supplies. The polling rate is 64 Hz by default. It rises to the requested periodic rate when the periodic source is on and asks for more than 64 Hz. Every source that fires on a poll is merged into one interrupt request, and a flag word tells the receiver which sources fired.

Polls are scheduled against a deadline that is kept in reference ticks. When every source is off the scheduler stops. The first source enabled from that idle state restarts it one poll interval later. When the time-of-day counter signals that its value is being rewritten, polling is held off. Once the hold ends, the engine works out how many intervals were missed. It moves the next deadline past them plus one spare interval, and it credits the missed intervals to the periodic divider, so the periodic rate is kept on average.

Software programs the engine through a four-entry write port. The entries are: set enables, clear enables, alarm time, and periodic rate code.

Top module: `tod_irq_engine`

## Requirements
- R1: Polls occur every 2^(REF_LOG2-6) reference ticks (64 Hz) unless the periodic source is enabled with a rate code above 6. In that case they occur every 2^(REF_LOG2-code) reference ticks. The update and alarm sources are evaluated on every poll at that rate.
- R2: The periodic rate is written as a 4-bit code meaning 2^code Hz. A code below 1 is taken as 1, and a code above REF_LOG2 (13 by default) is taken as REF_LOG2.
- R3: The periodic source counts polls and fires when the count reaches (poll rate / requested rate), then restarts from zero. Its interrupts are therefore spaced 2^(REF_LOG2-code) reference ticks apart for every code.
- R4: The update source fires on a poll where `seconds` differs from the recorded value, and then records the new value. The recorded value is 63 after reset.
- R5: The alarm source fires on every poll where hours, minutes and seconds all equal the programmed alarm time. A mismatch in any one field suppresses it.
- R6: The flag word carries the update flag in bit 4, the alarm flag in bit 5, the periodic flag in bit 6, an interrupt-present flag in bit 7 and an interrupt count of 1 in bits 15:8. Bits 3:0 are zero.
- R7: `irq` is a one-cycle pulse in the cycle after the poll that fired. `irqFlags` is valid in the same cycle and zero in every cycle without `irq`.
- R8: A write that enables the periodic source, or any write of a rate code, clears the periodic poll count.
- R9: With all sources disabled no poll takes place. When a source is enabled from that idle state, the first poll comes one poll interval after the enabling write. The resulting interrupt appears 1 + (the interval to the first firing poll) cycles after the write edge.
- R10: If polls were missed while `todBusy` was high, the late poll moves the deadline past the missed intervals plus one extra interval. The missed count, floor(lateness/interval)+1, is added to the periodic count before that poll's own increment.
- R11: Writes use `wrAddr` 0 to set enables and `wrAddr` 1 to clear them. In both, `wrData` bit 0 is update, bit 1 is alarm and bit 2 is periodic. `wrAddr` 2 loads the alarm time with hours in the top HR_W bits, then minutes, then seconds in the low SEC_W bits. `wrAddr` 3 loads the rate code from `wrData[3:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference tick at 2^REF_LOG2 Hz, one cycle wide |
| todBusy | input | 1 | Time-of-day value is being rewritten; polls are held off |
| hours | input | HR_W | Current hours |
| minutes | input | MIN_W | Current minutes |
| seconds | input | SEC_W | Current seconds |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | HR_W+MIN_W+SEC_W | Write data |
| irq | output | 1 | Interrupt pulse |
| irqFlags | output | 16 | Source flags and count, valid with `irq` |

## Verification
If the deadline register is wrong, the spacing of interrupt pulses changes. This shows within one poll interval at 64 Hz and within a single periodic period in the rate sweep. A wrong periodic count shows as a first-interrupt latency or an inter-pulse gap that differs from 2^(13-code) by whole poll intervals. The clear-on-write and catch-up tests make that difference hundreds of cycles wide. A stale recorded second or a bad alarm compare shows as a missing or extra update or alarm flag on the very next poll.

// File: rtl/tod_irq_pkg.sv
package tod_irq_pkg;

  localparam int LOG_W = 5;

  // Flag word layout decoded by the interrupt receiver
  localparam int FLAG_UPD = 4;
  localparam int FLAG_ALM = 5;
  localparam int FLAG_PER = 6;
  localparam int FLAG_IRQ = 7;
  localparam logic [7:0] INT_COUNT = 8'd1;

  typedef enum logic [1:0] {
    ADDR_SET   = 2'd0,
    ADDR_CLR   = 2'd1,
    ADDR_ALARM = 2'd2,
    ADDR_FREQ  = 2'd3
  } regAddr_t;

  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic             restart;   // rearm the deadline from the current time
    logic             clrPer;    // clear periodic poll count
    logic             updOn;
    logic             almOn;
    logic             perOn;
    logic [LOG_W-1:0] intLog2;   // log2 of poll interval in reference ticks
    logic [LOG_W-1:0] thrLog2;   // log2 of polls per periodic interrupt
  } ctrlStrobes_t;

endpackage

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl
  import tod_irq_pkg::*;
#(
  parameter int REF_LOG2 = 13,
  parameter int DEF_LOG2 = 6,
  parameter int MIN_LOG2 = 1,
  parameter int HR_W     = 5,
  parameter int MIN_W    = 6,
  parameter int SEC_W    = 6,
  localparam int DATA_W  = HR_W + MIN_W + SEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlStrobes_t      ctl,
  output logic [HR_W-1:0]   almHr,
  output logic [MIN_W-1:0]  almMin,
  output logic [SEC_W-1:0]  almSec
);

  localparam logic [LOG_W-1:0] DEF_C = LOG_W'(DEF_LOG2);
  localparam logic [LOG_W-1:0] MIN_C = LOG_W'(MIN_LOG2);
  localparam logic [LOG_W-1:0] MAX_C = LOG_W'(REF_LOG2);
  localparam logic [LOG_W-1:0] REF_C = LOG_W'(REF_LOG2);

  logic             updOn, almOn, perOn;
  logic             restartQ;
  logic [LOG_W-1:0] freqSel;
  logic [LOG_W-1:0] baseLog;
  logic             anyOn;
  logic             setHit, freqHit;

  function automatic logic [LOG_W-1:0] clampCode(input logic [3:0] code);
    logic [LOG_W-1:0] wide;
    wide = LOG_W'(code);
    if (wide < MIN_C)      return MIN_C;
    else if (wide > MAX_C) return MAX_C;
    else                   return wide;
  endfunction

  assign anyOn   = updOn | almOn | perOn;
  assign setHit  = wrEn && (regAddr_t'(wrAddr) == ADDR_SET);
  assign freqHit = wrEn && (regAddr_t'(wrAddr) == ADDR_FREQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updOn    <= 1'b0;
      almOn    <= 1'b0;
      perOn    <= 1'b0;
      restartQ <= 1'b0;
      freqSel  <= DEF_C;
      almHr    <= '0;
      almMin   <= '0;
      almSec   <= '0;
    end else begin
      restartQ <= setHit && (|wrData[2:0]) && !anyOn;
      if (wrEn) begin
        case (regAddr_t'(wrAddr))
          ADDR_SET: begin
            updOn <= updOn | wrData[0];
            almOn <= almOn | wrData[1];
            perOn <= perOn | wrData[2];
          end
          ADDR_CLR: begin
            updOn <= updOn & ~wrData[0];
            almOn <= almOn & ~wrData[1];
            perOn <= perOn & ~wrData[2];
          end
          ADDR_ALARM: begin
            almHr  <= wrData[DATA_W-1 -: HR_W];
            almMin <= wrData[SEC_W +: MIN_W];
            almSec <= wrData[SEC_W-1:0];
          end
          default: freqSel <= clampCode(wrData[3:0]);
        endcase
      end
    end
  end

  // Base rate: default unless periodic asks for more
  always_comb begin
    baseLog = (perOn && (freqSel > DEF_C)) ? freqSel : DEF_C;
    ctl.restart = restartQ;
    ctl.clrPer  = (setHit && wrData[2]) || freqHit;
    ctl.updOn   = updOn;
    ctl.almOn   = almOn;
    ctl.perOn   = perOn;
    ctl.intLog2 = REF_C - baseLog;
    ctl.thrLog2 = (freqSel <= baseLog) ? (baseLog - freqSel) : '0;
  end

  // R2: the stored code never leaves the legal range
  a_r2_code_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (freqSel >= MIN_C) && (freqSel <= MAX_C));

  // R11: a set-enable write leaves the addressed enables on
  a_r11_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    setHit |=> ((updOn || !$past(wrData[0])) && (almOn || !$past(wrData[1]))
                && (perOn || !$past(wrData[2]))));

endmodule

// File: rtl/tod_irq_datapath.sv
module tod_irq_datapath
  import tod_irq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HR_W  = 5,
  parameter int MIN_W = 6,
  parameter int SEC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             todBusy,
  input  logic [HR_W-1:0]  hours,
  input  logic [MIN_W-1:0] minutes,
  input  logic [SEC_W-1:0] seconds,
  input  ctrlStrobes_t     ctl,
  input  logic [HR_W-1:0]  almHr,
  input  logic [MIN_W-1:0] almMin,
  input  logic [SEC_W-1:0] almSec,
  output logic             irq,
  output logic [15:0]      irqFlags
);

  localparam logic [SEC_W-1:0] SEC_NONE = '1;

  logic [CNT_W-1:0] nowCnt, dueCnt, perCnt;
  logic [SEC_W-1:0] prevSec;

  logic             running, pollHit, isLate;
  logic [CNT_W-1:0] diffNow, intStep, stepDue, lateBy, lostCnt, nextDue;
  logic [CNT_W:0]   perSum, perLimit;
  logic             updFire, almFire, perFire, anyFire;

  // Deadline scheduling
  always_comb begin
    running = ctl.updOn | ctl.almOn | ctl.perOn;
    diffNow = nowCnt - dueCnt;
    pollHit = running && !ctl.restart && !todBusy && !diffNow[CNT_W-1];
    intStep = CNT_W'(1) << ctl.intLog2;
    stepDue = dueCnt + intStep;
    lateBy  = nowCnt - stepDue;
    isLate  = !lateBy[CNT_W-1] && (lateBy != '0);
    lostCnt = isLate ? ((lateBy >> ctl.intLog2) + CNT_W'(1)) : '0;
    nextDue = isLate ? (stepDue + ((lostCnt + CNT_W'(1)) << ctl.intLog2)) : stepDue;
  end

  // Source evaluation
  always_comb begin
    perSum   = {1'b0, perCnt} + {1'b0, lostCnt} + (CNT_W+1)'(1);
    perLimit = (CNT_W+1)'(1) << ctl.thrLog2;
    perFire  = pollHit && ctl.perOn && (perSum >= perLimit);
    updFire  = pollHit && ctl.updOn && (seconds != prevSec);
    almFire  = pollHit && ctl.almOn && (hours == almHr)
               && (minutes == almMin) && (seconds == almSec);
    anyFire  = updFire | almFire | perFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nowCnt   <= '0;
      dueCnt   <= '0;
      perCnt   <= '0;
      prevSec  <= SEC_NONE;
      irq      <= 1'b0;
      irqFlags <= '0;
    end else begin
      if (refTick) nowCnt <= nowCnt + CNT_W'(1);

      if (ctl.restart)  dueCnt <= nowCnt + intStep;
      else if (pollHit) dueCnt <= nextDue;

      if (ctl.clrPer)                 perCnt <= '0;
      else if (pollHit && ctl.perOn)  perCnt <= perFire ? '0 : perSum[CNT_W-1:0];

      if (updFire) prevSec <= seconds;

      irq <= anyFire;
      if (anyFire) begin
        irqFlags <= '0;
        irqFlags[15:8]   <= INT_COUNT;
        irqFlags[FLAG_IRQ] <= 1'b1;
        irqFlags[FLAG_PER] <= perFire;
        irqFlags[FLAG_ALM] <= almFire;
        irqFlags[FLAG_UPD] <= updFire;
      end else begin
        irqFlags <= '0;
      end
    end
  end

  // R3: the periodic count always stays below its limit
  a_r3_count_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.perOn |-> ({1'b0, perCnt} < perLimit));

  // R4: the seconds value that fired the update source is recorded
  a_r4_sec_recorded: assert property (@(posedge clk) disable iff (!rstN)
    updFire |=> (prevSec == $past(seconds)));

  // R7: no pulse and no flags without a poll in the cycle before
  a_r7_pulse_needs_poll: assert property (@(posedge clk) disable iff (!rstN)
    !pollHit |=> (!irq && (irqFlags == 16'd0)));

  // R6: every pulse carries the header and at least one source flag
  a_r6_flag_header: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((irqFlags[15:7] == 9'b0000_0001_1) && (|irqFlags[6:4])
             && (irqFlags[3:0] == 4'd0)));

  // R9: no sources enabled means no interrupt next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !irq);

  // R10: after a poll the deadline is never behind the poll time
  a_r10_deadline_ahead: assert property (@(posedge clk) disable iff (!rstN)
    pollHit |=> !((dueCnt - $past(nowCnt)) >> (CNT_W-1)));

endmodule

// File: rtl/tod_irq_engine.sv
module tod_irq_engine
  import tod_irq_pkg::*;
#(
  parameter int REF_LOG2 = 13,
  parameter int DEF_LOG2 = 6,
  parameter int CNT_W    = 16,
  parameter int HR_W     = 5,
  parameter int MIN_W    = 6,
  parameter int SEC_W    = 6,
  localparam int DATA_W  = HR_W + MIN_W + SEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              todBusy,
  input  logic [HR_W-1:0]   hours,
  input  logic [MIN_W-1:0]  minutes,
  input  logic [SEC_W-1:0]  seconds,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              irq,
  output logic [15:0]       irqFlags
);

  ctrlStrobes_t     ctl;
  logic [HR_W-1:0]  almHr;
  logic [MIN_W-1:0] almMin;
  logic [SEC_W-1:0] almSec;

  tod_irq_ctrl #(
    .REF_LOG2(REF_LOG2), .DEF_LOG2(DEF_LOG2), .MIN_LOG2(1),
    .HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctl(ctl), .almHr(almHr), .almMin(almMin), .almSec(almSec)
  );

  tod_irq_datapath #(
    .CNT_W(CNT_W), .HR_W(HR_W), .MIN_W(MIN_W), .SEC_W(SEC_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .refTick(refTick), .todBusy(todBusy),
    .hours(hours), .minutes(minutes), .seconds(seconds), .ctl(ctl),
    .almHr(almHr), .almMin(almMin), .almSec(almSec),
    .irq(irq), .irqFlags(irqFlags)
  );

endmodule

// File: tb/test_tod_irq_engine.sv
module test_tod_irq_engine;

  logic        clk = 1'b0;
  logic        rstN, refTick, todBusy, wrEn;
  logic [4:0]  hours;
  logic [5:0]  minutes, seconds;
  logic [1:0]  wrAddr;
  logic [16:0] wrData;
  logic        irq;
  logic [15:0] irqFlags;

  int cyc = 0;
  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tod_irq_engine i_tod_irq_engine (
    .clk(clk), .rstN(rstN), .refTick(refTick), .todBusy(todBusy),
    .hours(hours), .minutes(minutes), .seconds(seconds),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irq(irq), .irqFlags(irqFlags)
  );

  function automatic logic [15:0] expFlags(input bit u, input bit a, input bit p);
    return 16'h0180 | (16'(p) << 6) | (16'(a) << 5) | (16'(u) << 4);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [16:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIrq(input int maxC, output int at, output logic [15:0] fl,
                         output bit got);
    got = 1'b0; at = -1; fl = '0;
    for (int k = 0; k < maxC; k++) begin
      @(negedge clk);
      if (irq) begin
        got = 1'b1; at = cyc; fl = irqFlags;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int t0, at, prevAt, per;
    int clampC;
    logic [15:0] fl;
    bit got;

    rstN = 1'b0; refTick = 1'b1; todBusy = 1'b0; wrEn = 1'b0;
    wrAddr = '0; wrData = '0;
    hours = 5'd10; minutes = 6'd20; seconds = 6'd5;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R7 reset state
    check("R7 reset irq", int'(irq), 0);
    check("R7 reset flags", int'(irqFlags), 0);

    // R9 no source enabled: no interrupt
    waitIrq(400, at, fl, got);
    check("R9 idle silent", int'(got), 0);

    // R4 update source, R11 set address bit 0
    wr(2'd0, 17'h1); t0 = cyc;
    waitIrq(200, at, fl, got);
    check("R9 update restart latency", at - t0, 129);
    check("R4 first update flags", int'(fl), int'(expFlags(1, 0, 0)));
    @(negedge clk);
    check("R7 single-cycle pulse", int'(irq), 0);
    check("R7 flags cleared after pulse", int'(irqFlags), 0);
    waitIrq(300, at, fl, got);
    check("R4 unchanged seconds silent", int'(got), 0);
    seconds = 6'd6;
    waitIrq(140, at, fl, got);
    check("R4 seconds change fires", int'(got), 1);
    check("R4 seconds change flags", int'(fl), int'(expFlags(1, 0, 0)));
    wr(2'd1, 17'h7);
    waitIrq(400, at, fl, got);
    check("R9 disabled all silent", int'(got), 0);

    // R5 alarm
    seconds = 6'd30;
    wr(2'd2, {5'd10, 6'd20, 6'd30});
    wr(2'd0, 17'h2); t0 = cyc;
    waitIrq(200, at, fl, got);
    check("R5 alarm latency", at - t0, 129);
    check("R5 alarm flags", int'(fl), int'(expFlags(0, 1, 0)));
    prevAt = at;
    waitIrq(200, at, fl, got);
    check("R5 alarm repeats each poll", at - prevAt, 128);
    seconds = 6'd31;
    waitIrq(300, at, fl, got);
    check("R5 seconds mismatch silent", int'(got), 0);
    seconds = 6'd30; hours = 5'd11;
    waitIrq(300, at, fl, got);
    check("R5 hours mismatch silent", int'(got), 0);
    hours = 5'd10; minutes = 6'd21;
    waitIrq(300, at, fl, got);
    check("R5 minutes mismatch silent", int'(got), 0);
    minutes = 6'd20;
    waitIrq(200, at, fl, got);
    check("R5 match again fires", int'(fl), int'(expFlags(0, 1, 0)));
    wr(2'd1, 17'h7);

    // R1 R2 R3 R9 sweep over every rate code
    for (int c = 0; c < 16; c++) begin
      wr(2'd1, 17'h7);
      repeat (3) @(negedge clk);
      wr(2'd3, 17'(c));
      wr(2'd0, 17'h4); t0 = cyc;
      clampC = (c < 1) ? 1 : ((c > 13) ? 13 : c);
      per = 1 << (13 - clampC);
      waitIrq(per + 10, at, fl, got);
      check($sformatf("R3 code %0d first latency (R9)", c), at - t0, per + 1);
      check($sformatf("R6 code %0d periodic flags", c), int'(fl), int'(expFlags(0, 0, 1)));
      prevAt = at;
      waitIrq(per + 10, at, fl, got);
      check($sformatf("R2 code %0d spacing (R1 R3)", c), at - prevAt, per);
    end
    wr(2'd1, 17'h7);

    // R8 periodic enable rewrite clears the count
    wr(2'd3, 17'd5);
    wr(2'd0, 17'h4);
    waitIrq(600, at, fl, got);
    prevAt = at;
    repeat (150) @(negedge clk);
    wr(2'd0, 17'h4);
    waitIrq(600, at, fl, got);
    check("R8 enable rewrite clears count", at - prevAt, 384);
    prevAt = at;
    repeat (150) @(negedge clk);
    wr(2'd3, 17'd5);
    waitIrq(600, at, fl, got);
    check("R8 rate write clears count", at - prevAt, 384);
    wr(2'd1, 17'h7);

    // R10 catch-up after missed polls
    wr(2'd3, 17'd3);
    wr(2'd0, 17'h4);
    waitIrq(2000, at, fl, got);
    prevAt = at;
    todBusy = 1'b1;
    repeat (1100) @(negedge clk);
    todBusy = 1'b0;
    waitIrq(3000, at, fl, got);
    check("R10 late poll fires with lost credit", at - prevAt, 1101);
    check("R10 late poll flags", int'(fl), int'(expFlags(0, 0, 1)));
    waitIrq(3000, at, fl, got);
    check("R10 deadline skips one extra interval", at - prevAt, 2176);
    wr(2'd1, 17'h7);

    // R6 all three sources together
    seconds = 6'd40;
    wr(2'd2, {5'd10, 6'd20, 6'd40});
    wr(2'd3, 17'd6);
    wr(2'd0, 17'h7); t0 = cyc;
    waitIrq(200, at, fl, got);
    check("R6 combined latency", at - t0, 129);
    check("R6 all flags", int'(fl), int'(expFlags(1, 1, 1)));
    prevAt = at;
    waitIrq(200, at, fl, got);
    check("R6 alarm and periodic flags", int'(fl), int'(expFlags(0, 1, 1)));
    check("R6 combined spacing", at - prevAt, 128);
    wr(2'd1, 17'h7);

    // R1 update polled at the raised rate
    wr(2'd3, 17'd8);
    wr(2'd0, 17'h5); t0 = cyc;
    waitIrq(100, at, fl, got);
    check("R1 raised rate latency", at - t0, 33);
    check("R1 same seconds no update flag", int'(fl), int'(expFlags(0, 0, 1)));
    seconds = 6'd41;
    prevAt = at;
    waitIrq(100, at, fl, got);
    check("R1 update seen at raised rate", int'(fl), int'(expFlags(1, 0, 1)));
    check("R1 raised rate spacing", at - prevAt, 32);
    wr(2'd1, 17'h7);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule